// File: doc/BRIEF.md
# Descriptor Ring DMA Pipe

This block is one DMA pipe driven by a circular ring of 8-byte descriptors in memory. Software sets the ring base and the ring size in bytes, then enables the pipe. It starts work by writing a producer byte offset into the event register. The pipe reads one descriptor at a time through a simple memory read port, decodes it, and hands one data-move request to an external data mover. When the mover reports done, the consumer offset moves forward by one descriptor and wraps to zero at the ring size.

Completion events come from the flag bits of each descriptor. They are collected in a sticky flag register that drives a single interrupt line. Software can stop new fetches with a halt bit, and can return the whole pipe to its defaults with a reset bit.

Registers sit behind a 3-bit word address. Reads are combinational. A write takes effect at the clock edge.

Top module: `dma_ring_pipe`

## Requirements
- R1: After `rst_ni` is released, these all read zero: the consumer offset (address 2), the flag register (address 7), `mem_req_o`, `mv_req_o` and `irq_o`.
- R2: A descriptor arrives on `mem_rdata_i` as 64 bits:
  - bits 31:0 are the buffer address;
  - bits 47:32 are the byte count;
  - bits 63:48 are the flags.
  The mover request carries the address on `mv_addr_o`, the count on `mv_len_o`, and flag bit 12 (fence) on `mv_fence_o`.
- R3: Writing a byte offset to the event register (address 1) sets the producer. The pipe then processes descriptors in ring order, from the consumer up to the producer, and stops when the consumer (address 2, low 16 bits) equals the producer.
- R4: The consumer steps by 8. When the step would reach or pass the ring size (address 6), the consumer becomes 0. Each fetch reads address base + consumer.
- R5: An event write that leaves the producer equal to the consumer starts no fetch and leaves the consumer unchanged.
- R6: A descriptor with a byte count of zero completes without a mover request. Its flags still take effect.
- R7: There is at most one outstanding request, either a fetch or a move:
  - a fetch request is held until `mem_rvalid_i`;
  - a mover request is held, with a stable address, until `mv_done_i`;
  - the consumer advances only after that completion.
- R8: The flag register (address 7) collects events on completion:
  - bit 0 when descriptor flag 15 (interrupt) is set;
  - bit 1 for descriptor flag 14 (end of transfer);
  - bit 2 for descriptor flag 13 (end of block).
  The bits stay set until software writes 1 to them. `irq_o` is the OR of all flag bits.
- R9: Flag bit 3 (out of descriptors) is set when a completion brings the consumer to the producer and that last descriptor lacks the end-of-transfer flag.
- R10: While the halt register (address 3, bit 0) holds 1, no new descriptor fetch starts. Writing 0 resumes from the stored consumer offset.
- R11: While the reset register (address 4, bit 0) holds 1, the pipe is held at its defaults:
  - control, halt, base, size, producer, consumer and flags all read zero;
  - any request is dropped.
  Writing 0 releases the pipe, which then stays idle.
- R12: The control register (address 0) keeps three bits: enable at bit 1, direction at bit 3 (peripheral-to-memory, driven on `mv_dir_o`) and system mode at bit 5. With enable clear, no fetch starts.
- R13: The base register (address 5) forces its low 3 bits to zero, so descriptor fetches are always 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Descriptor fetch request |
| mem_addr_o | output | 32 | Descriptor fetch address |
| mem_rvalid_i | input | 1 | Fetch data valid |
| mem_rdata_i | input | 64 | Fetched descriptor |
| mv_req_o | output | 1 | Data-move request |
| mv_addr_o | output | 32 | Buffer address of the move |
| mv_len_o | output | 16 | Byte count of the move |
| mv_dir_o | output | 1 | Direction, 1 = peripheral to memory |
| mv_fence_o | output | 1 | Fence flag of the descriptor |
| mv_done_i | input | 1 | Data mover completion |
| irq_o | output | 1 | OR of the sticky event flags |

## Verification
A corrupted consumer offset shows up at the very next fetch, as a wrong `mem_addr_o`, and again on the offset register once the batch drains. A wrong wrap point sends the fetch outside the ring within one descriptor of the boundary. A decode slip, or a missed zero-count skip, shows as a wrong address, length or fence on the following mover request, or as a wrong number of requests. Flag mistakes become visible in the flag register and `irq_o` one cycle after the completing descriptor.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int DESC_BYTES = 8;

  // descriptor flag bit positions
  localparam int FLG_INT   = 15;
  localparam int FLG_EOT   = 14;
  localparam int FLG_EOB   = 13;
  localparam int FLG_FENCE = 12;

  // event flag register bits
  localparam int EV_DONE = 0;
  localparam int EV_EOT  = 1;
  localparam int EV_EOB  = 2;
  localparam int EV_OOD  = 3;
  localparam int EV_W    = 4;

  // control register bits
  localparam int CTRL_EN  = 1;
  localparam int CTRL_DIR = 3;
  localparam int CTRL_SYS = 5;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_EVENT = 3'd1;
  localparam logic [2:0] RA_CONS  = 3'd2;
  localparam logic [2:0] RA_HALT  = 3'd3;
  localparam logic [2:0] RA_RESET = 3'd4;
  localparam logic [2:0] RA_BASE  = 3'd5;
  localparam logic [2:0] RA_SIZE  = 3'd6;
  localparam logic [2:0] RA_FLAGS = 3'd7;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] count;
    logic [31:0] addr;
  } desc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE} eng_st_e;
endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
  import dma_ring_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [OFS_W-1:0] cons_i,
  input  logic [EV_W-1:0]  flag_set_i,
  output logic             en_o,
  output logic             dir_o,
  output logic             halt_o,
  output logic             pipe_rst_o,
  output logic [DW-1:0]    base_o,
  output logic [OFS_W-1:0] size_o,
  output logic [OFS_W-1:0] prod_o,
  output logic             irq_o
);
  logic [2:0]       ctrl_q;   // {sys, dir, en}
  logic             halt_q, rst_q;
  logic [DW-1:0]    base_q;
  logic [OFS_W-1:0] size_q, prod_q;
  logic [EV_W-1:0]  flags_q, clr;

  assign clr = (we_i && addr_i == RA_FLAGS) ? wdata_i[EV_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b0;
      ctrl_q  <= '0;
      halt_q  <= 1'b0;
      base_q  <= '0;
      size_q  <= '0;
      prod_q  <= '0;
      flags_q <= '0;
    end else begin
      if (we_i && addr_i == RA_RESET) rst_q <= wdata_i[0];
      if (rst_q) begin
        ctrl_q  <= '0;
        halt_q  <= 1'b0;
        base_q  <= '0;
        size_q  <= '0;
        prod_q  <= '0;
        flags_q <= '0;
      end else begin
        flags_q <= (flags_q & ~clr) | flag_set_i;
        if (we_i) begin
          case (addr_i)
            RA_CTRL:  ctrl_q <= {wdata_i[CTRL_SYS], wdata_i[CTRL_DIR], wdata_i[CTRL_EN]};
            RA_EVENT: prod_q <= wdata_i[OFS_W-1:0];
            RA_HALT:  halt_q <= wdata_i[0];
            RA_BASE:  base_q <= {wdata_i[DW-1:3], 3'b000};
            RA_SIZE:  size_q <= wdata_i[OFS_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: begin
        rdata_o[CTRL_EN]  = ctrl_q[0];
        rdata_o[CTRL_DIR] = ctrl_q[1];
        rdata_o[CTRL_SYS] = ctrl_q[2];
      end
      RA_EVENT: rdata_o[OFS_W-1:0] = prod_q;
      RA_CONS:  rdata_o[OFS_W-1:0] = cons_i;
      RA_HALT:  rdata_o[0]         = halt_q;
      RA_RESET: rdata_o[0]         = rst_q;
      RA_BASE:  rdata_o            = base_q;
      RA_SIZE:  rdata_o[OFS_W-1:0] = size_q;
      default:  rdata_o[EV_W-1:0]  = flags_q;
    endcase
  end

  assign en_o       = ctrl_q[0];
  assign dir_o      = ctrl_q[1];
  assign halt_o     = halt_q;
  assign pipe_rst_o = rst_q;
  assign base_o     = base_q;
  assign size_o     = size_q;
  assign prod_o     = prod_q;
  assign irq_o      = |flags_q;
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
  import dma_ring_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             halt_i,
  input  logic [DW-1:0]    base_i,
  input  logic [OFS_W-1:0] size_i,
  input  logic [OFS_W-1:0] prod_i,
  output logic             mem_req_o,
  output logic [DW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             mv_req_o,
  output logic [31:0]      mv_addr_o,
  output logic [15:0]      mv_len_o,
  output logic             mv_fence_o,
  input  logic             mv_done_i,
  output logic [OFS_W-1:0] cons_o,
  output logic [EV_W-1:0]  flag_set_o
);
  localparam logic [OFS_W:0] STEP = (OFS_W+1)'(DESC_BYTES);

  eng_st_e          st_q;
  desc_t            desc_q, rd_desc, cur;
  logic [OFS_W-1:0] cons_q, nxt;
  logic [OFS_W:0]   inc;
  logic             fin, zero_len;

  assign rd_desc  = desc_t'(mem_rdata_i);
  assign zero_len = (rd_desc.count == '0);
  assign inc      = {1'b0, cons_q} + STEP;
  assign nxt      = (inc >= {1'b0, size_i}) ? '0 : inc[OFS_W-1:0];
  assign cur      = (st_q == ST_MOVE) ? desc_q : rd_desc;
  assign fin      = (st_q == ST_FETCH && mem_rvalid_i && zero_len) ||
                    (st_q == ST_MOVE && mv_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cons_q <= '0;
      desc_q <= '0;
    end else if (clr_i) begin
      st_q   <= ST_IDLE;
      cons_q <= '0;
      desc_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (en_i && !halt_i && prod_i != cons_q) st_q <= ST_FETCH;
        ST_FETCH: if (mem_rvalid_i) begin
          desc_q <= rd_desc;
          st_q   <= zero_len ? ST_IDLE : ST_MOVE;
        end
        default:  if (mv_done_i) st_q <= ST_IDLE;
      endcase
      if (fin) cons_q <= nxt;
    end
  end

  always_comb begin
    flag_set_o = '0;
    if (fin) begin
      flag_set_o[EV_DONE] = cur.flags[FLG_INT];
      flag_set_o[EV_EOT]  = cur.flags[FLG_EOT];
      flag_set_o[EV_EOB]  = cur.flags[FLG_EOB];
      flag_set_o[EV_OOD]  = (nxt == prod_i) && !cur.flags[FLG_EOT];
    end
  end

  assign mem_req_o  = (st_q == ST_FETCH);
  assign mem_addr_o = base_i + {{(DW-OFS_W){1'b0}}, cons_q};
  assign mv_req_o   = (st_q == ST_MOVE);
  assign mv_addr_o  = desc_q.addr;
  assign mv_len_o   = desc_q.count;
  assign mv_fence_o = desc_q.flags[FLG_FENCE];
  assign cons_o     = cons_q;
endmodule

// File: rtl/dma_ring_pipe.sv
module dma_ring_pipe
  import dma_ring_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [63:0]   mem_rdata_i,
  output logic          mv_req_o,
  output logic [31:0]   mv_addr_o,
  output logic [15:0]   mv_len_o,
  output logic          mv_dir_o,
  output logic          mv_fence_o,
  input  logic          mv_done_i,
  output logic          irq_o
);
  logic             en, halt, pipe_rst;
  logic [DW-1:0]    base;
  logic [OFS_W-1:0] size, prod, cons;
  logic [EV_W-1:0]  flag_set;

  dma_ring_regs #(.DW(DW), .OFS_W(OFS_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cons_i(cons), .flag_set_i(flag_set),
    .en_o(en), .dir_o(mv_dir_o), .halt_o(halt), .pipe_rst_o(pipe_rst),
    .base_o(base), .size_o(size), .prod_o(prod), .irq_o
  );

  dma_ring_engine #(.DW(DW), .OFS_W(OFS_W)) u_eng (
    .clk_i, .rst_ni, .clr_i(pipe_rst), .en_i(en), .halt_i(halt),
    .base_i(base), .size_i(size), .prod_i(prod),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .mv_req_o, .mv_addr_o, .mv_len_o, .mv_fence_o, .mv_done_i,
    .cons_o(cons), .flag_set_o(flag_set)
  );
endmodule

// File: rtl/dma_ring_pipe_chk.sv
module dma_ring_pipe_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_req_o,
  input logic             mem_rvalid_i,
  input logic             mv_req_o,
  input logic             mv_done_i,
  input logic [31:0]      mv_addr_o,
  input logic [OFS_W-1:0] cons,
  input logic             pipe_rst,
  input logic             halt
);
  assert_single_outstanding_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && mv_req_o));

  assert_fetch_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i && !pipe_rst) |=> mem_req_o);

  assert_move_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_req_o && !mv_done_i && !pipe_rst) |=> (mv_req_o && $stable(mv_addr_o)));

  assert_cons_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons != $past(cons)) |-> (cons == '0 || cons == $past(cons) + OFS_W'(8)));

  assert_cons_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons[2:0] == 3'b000);

  assert_halt_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !mem_req_o && !mv_req_o && !pipe_rst) |=> !mem_req_o);

  assert_reset_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_rst |=> (cons == '0 && !mv_req_o && !mem_req_o));
endmodule

bind dma_ring_pipe dma_ring_pipe_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_rvalid_i(mem_rvalid_i),
  .mv_req_o(mv_req_o), .mv_done_i(mv_done_i), .mv_addr_o(mv_addr_o),
  .cons(cons), .pipe_rst(pipe_rst), .halt(halt)
);

// File: tb/tb_dma_ring_pipe.sv
module tb_dma_ring_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;
  localparam logic [31:0] BASE = 32'h8000_0040;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        mem_req_o, mem_rvalid_i;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_rdata_i;
  logic        mv_req_o, mv_dir_o, mv_fence_o, irq_o;
  logic        mv_done_i = 1'b0;
  logic [31:0] mv_addr_o;
  logic [15:0] mv_len_o;

  int errors = 0, checks = 0, fetch_n = 0, rec_n = 0, mv_cnt = 0, cons_m = 0;
  logic [31:0] rec_addr [0:15];
  logic [15:0] rec_len  [0:15];
  logic        rec_fence[0:15];
  logic        rec_dir  [0:15];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_ring_pipe dut (.*);

  function automatic logic [31:0] d_addr(int s); return 32'h2000_0000 + 32'(s) * 32'h40; endfunction
  function automatic logic [15:0] d_len(int s); return (s % 4 == 0) ? 16'd0 : 16'(16 * s); endfunction
  function automatic logic [15:0] d_flg(int s);
    return {(s % 3 == 0), (s == 3 || s == 7), (s % 2 == 1), (s % 4 == 2), 12'h000};
  endfunction

  // memory model: answers in the same cycle, contents computed from slot
  int slot_rd;
  assign mem_rvalid_i = mem_req_o;
  always_comb begin
    slot_rd = int'((mem_addr_o - BASE) >> 3) % SLOTS;
    mem_rdata_i = {d_flg(slot_rd), d_len(slot_rd), d_addr(slot_rd)};
  end

  always @(posedge clk_i) if (mem_req_o && mem_rvalid_i) fetch_n++;

  // data mover stub: done after three cycles, records each accepted request
  always @(negedge clk_i) begin
    if (mv_req_o && !mv_done_i) begin
      if (mv_cnt == 2) begin
        mv_done_i = 1'b1;
        mv_cnt = 0;
        if (rec_n < 16) begin
          rec_addr[rec_n] = mv_addr_o; rec_len[rec_n] = mv_len_o;
          rec_fence[rec_n] = mv_fence_o; rec_dir[rec_n] = mv_dir_o;
        end
        rec_n++;
      end else mv_cnt++;
    end else begin
      mv_done_i = 1'b0;
      if (!mv_req_o) mv_cnt = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk_i); reg_addr_i = a; #1 v = reg_rdata_o;
  endtask

  task automatic wait_idle(input int target);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i); reg_addr_i = 3'd2; #1;
      if (reg_rdata_o[15:0] == 16'(target) && !mem_req_o && !mv_req_o) return;
    end
    check("R3 drain timeout", 32'd0, 32'd1);
  endtask

  task automatic run_batch(input int k, input logic dir);
    int c, pn, n;
    logic [3:0] fe;
    logic [31:0] v;
    logic [31:0] ea [0:15];
    logic [15:0] el [0:15];
    logic        ef [0:15];
    c = cons_m / 8; pn = ((c + k) % SLOTS) * 8; n = 0; fe = '0;
    for (int j = 0; j < k; j++) begin
      int s = (c + j) % SLOTS;
      if (d_len(s) != 0) begin ea[n] = d_addr(s); el[n] = d_len(s); ef[n] = d_flg(s)[12]; n++; end
      fe[0] |= d_flg(s)[15]; fe[1] |= d_flg(s)[14]; fe[2] |= d_flg(s)[13];
      if (j == k - 1) fe[3] = !d_flg(s)[14];
    end
    rec_n = 0;
    wr(3'd1, 32'(pn));
    wait_idle(pn);
    rd(3'd2, v);
    check((c + k >= SLOTS) ? "R4 consumer after wrap" : "R3 consumer at producer", v, 32'(pn));
    check("R6 request count (zero-length skipped)", 32'(rec_n), 32'(n));
    for (int i = 0; i < n && i < rec_n; i++) begin
      check("R2 mover address", rec_addr[i], ea[i]);
      check("R2 mover length", 32'(rec_len[i]), 32'(el[i]));
      check("R2 mover fence", 32'(rec_fence[i]), 32'(ef[i]));
      check("R12 mover direction", 32'(rec_dir[i]), 32'(dir));
    end
    rd(3'd7, v);
    check("R8 event flags", {29'd0, v[2:0]}, {29'd0, fe[2:0]});
    check("R9 out-of-descriptors flag", 32'(v[3]), 32'(fe[3]));
    check("R8 irq line", 32'(irq_o), 32'(|fe));
    wr(3'd7, 32'hF);
    rd(3'd7, v);
    check("R8 write-1 clear", v, 32'd0);
    cons_m = pn;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int f0, tgt;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(3'd2, v); check("R1 consumer reset", v, 32'd0);
    rd(3'd7, v); check("R1 flags reset", v, 32'd0);
    check("R1 no requests", {30'd0, mem_req_o, mv_req_o}, 32'd0);
    check("R1 irq low", 32'(irq_o), 32'd0);

    wr(3'd5, BASE | 32'h7);
    rd(3'd5, v); check("R13 base aligned", v, BASE);
    wr(3'd6, 32'(SLOTS * 8));

    // enable clear: nothing may start
    f0 = fetch_n;
    wr(3'd1, 32'd16);
    repeat (10) @(negedge clk_i);
    check("R12 disabled pipe idle", 32'(fetch_n - f0), 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h22);
    rd(3'd0, v); check("R12 control readback", v, 32'h22);

    for (int k = 1; k < SLOTS; k++) run_batch(k, 1'b0);
    wr(3'd0, 32'h2A);
    for (int k = SLOTS - 1; k >= 1; k--) run_batch(k, 1'b1);

    // same producer starts nothing
    f0 = fetch_n;
    wr(3'd1, 32'(cons_m));
    repeat (10) @(negedge clk_i);
    check("R5 no fetch on equal offsets", 32'(fetch_n - f0), 32'd0);
    rd(3'd2, v); check("R5 consumer unchanged", v, 32'(cons_m));

    // halt
    wr(3'd3, 32'd1);
    tgt = (cons_m + 16) % (SLOTS * 8);
    f0 = fetch_n;
    wr(3'd1, 32'(tgt));
    repeat (12) @(negedge clk_i);
    check("R10 no fetch while halted", 32'(fetch_n - f0), 32'd0);
    rd(3'd2, v); check("R10 consumer held", v, 32'(cons_m));
    wr(3'd3, 32'd0);
    wait_idle(tgt);
    rd(3'd2, v); check("R10 resumed to producer", v, 32'(tgt));
    wr(3'd7, 32'hF);
    cons_m = tgt;

    // pipe reset in flight
    wr(3'd1, 32'((cons_m + 40) % (SLOTS * 8)));
    repeat (3) @(negedge clk_i);
    wr(3'd4, 32'd1);
    rd(3'd2, v); check("R11 consumer cleared", v, 32'd0);
    rd(3'd0, v); check("R11 control cleared", v, 32'd0);
    rd(3'd5, v); check("R11 base cleared", v, 32'd0);
    rd(3'd1, v); check("R11 producer cleared", v, 32'd0);
    check("R11 requests dropped", {30'd0, mem_req_o, mv_req_o}, 32'd0);
    wr(3'd4, 32'd0);
    f0 = fetch_n;
    repeat (10) @(negedge clk_i);
    check("R11 idle after release", 32'(fetch_n - f0), 32'd0);
    rd(3'd7, v); check("R11 flags cleared", v, 32'd0);
    cons_m = 0;
    wr(3'd5, BASE);
    wr(3'd6, 32'(SLOTS * 8));
    wr(3'd0, 32'h22);
    run_batch(5, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule